// File: doc/BRIEF.md
# Bank-Switched Address Translator

This purely combinational block turns three kinds of logical address into physical memory addresses for a cartridge-style memory system. CPU program addresses in the upper 32 KB window go to a program ROM address. Video pattern addresses go to a character memory address. Video nametable addresses go to an address in a 2 KB on-board table RAM. A 5-bit control word chooses the program layout, the character bank granularity and the nametable mirroring. Bank numbers come in on separate inputs, and the logic that loads them lives elsewhere.

The program ROM size and the character ROM size are parameters, each a power of two: 16 KB units for program ROM and 4 KB units for character ROM. Bank numbers wrap modulo the number of banks present. A flag input marks character memory as RAM, and in that case pattern addresses bypass banking. The block also provides the save-RAM offset, which is the low 13 bits of the CPU address.

Top module: `bank_xlat`

## Requirements
- R1: With control bit 3 = 0, the program address is ((bank & ~1) * 16384) + cpu_addr[14:0], so the whole 32 KB window maps to one 32 KB bank and bank bit 0 is ignored.
- R2: With control bit 3 = 1 and bit 2 = 1, cpu_addr[14] = 0 maps to bank * 16384 + cpu_addr[13:0], and cpu_addr[14] = 1 maps to the last 16 KB bank of program ROM.
- R3: With control bit 3 = 1 and bit 2 = 0, cpu_addr[14] = 0 maps to bank 0 and cpu_addr[14] = 1 maps to the selected bank, each with offset cpu_addr[13:0].
- R4: With control bit 4 = 1 and character ROM in use, pattern addresses below 0x1000 use bank input 0 and the others use bank input 1. The address is bank * 4096 + pat_addr[11:0].
- R5: With control bit 4 = 0 and character ROM in use, the address is ((bank0 & ~1) * 4096) + pat_addr[12:0], and bank input 1 has no effect.
- R6: With chr_ram_i = 1, the character address equals pat_addr_i zero-extended, whatever the control and bank inputs are.
- R7: Control bits 1:0 = 0 give table address {0, nt_addr[9:0]}, and bits 1:0 = 1 give {1, nt_addr[9:0]}.
- R8: Control bits 1:0 = 2 give nt_addr[10:0]. Control bits 1:0 = 3 give {nt_addr[11], nt_addr[9:0]}.
- R9: The save-RAM address equals cpu_addr[12:0].
- R10: Program and character bank numbers are taken modulo the bank count set by the size parameters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ctrl_i | input | 5 | Control word: [4] 4 KB character banks, [3] 16 KB program banks, [2] fix last bank high, [1:0] mirroring |
| prg_bank_i | input | 4 | Program bank number |
| chr_bank0_i | input | 5 | Character bank number 0 |
| chr_bank1_i | input | 5 | Character bank number 1 |
| chr_ram_i | input | 1 | 1 = character memory is RAM (unbanked) |
| cpu_addr_i | input | 15 | CPU address offset within the 32 KB ROM window or the save-RAM window |
| pat_addr_i | input | 13 | Video pattern address |
| nt_addr_i | input | 12 | Video nametable address offset |
| prg_addr_o | output | 14+PRG_LOG2 | Physical program ROM address |
| chr_addr_o | output | 12+CHR_LOG2 | Physical character memory address |
| ciram_addr_o | output | 11 | Table RAM address |
| wram_addr_o | output | 13 | Save-RAM address |

## Verification
The block holds no state, so a wrong internal selection shows up at the outputs in the same cycle as the input that exposes it. A mis-decoded control field moves the upper address bits, and it only becomes visible when the address half or the bank number makes that field matter. For this reason every control value is swept against many bank numbers, including numbers beyond the bank count, and against addresses on either side of the 16 KB and 4 KB boundaries. A wrong mirroring choice shows only in address bit 10, so nametable addresses with bits 10 and 11 in every combination are used.

// File: rtl/bx_pkg.sv
package bx_pkg;
  typedef enum logic [1:0] {
    MIR_ONE_LO = 2'd0,
    MIR_ONE_HI = 2'd1,
    MIR_VERT   = 2'd2,
    MIR_HORIZ  = 2'd3
  } mirror_e;

  typedef struct packed {
    logic    chr_4k;
    logic    prg_16k;
    logic    fix_last;
    mirror_e mir;
  } ctrl_t;
endpackage

// File: rtl/bx_prg_map.sv
module bx_prg_map #(
  parameter int PB = 3
) (
  input  logic            prg_16k_i,
  input  logic            fix_last_i,
  input  logic [3:0]      bank_i,
  input  logic [14:0]     off_i,
  output logic [PB+13:0]  addr_o
);
  logic [PB-1:0] bank_w;
  logic [PB-1:0] win32;
  logic [PB-1:0] blk;

  assign bank_w = PB'(bank_i);

  generate
    if (PB > 1) begin : g_wide
      assign win32 = {bank_w[PB-1:1], off_i[14]};
    end else begin : g_one
      assign win32 = off_i[14];
    end
  endgenerate

  always_comb begin
    if (!prg_16k_i)      blk = win32;
    else if (fix_last_i) blk = off_i[14] ? '1 : bank_w;
    else                 blk = off_i[14] ? bank_w : '0;
  end

  assign addr_o = {blk, off_i[13:0]};
endmodule

// File: rtl/bx_chr_map.sv
module bx_chr_map #(
  parameter int CB = 4
) (
  input  logic            chr_4k_i,
  input  logic            is_ram_i,
  input  logic [4:0]      bank0_i,
  input  logic [4:0]      bank1_i,
  input  logic [12:0]     pat_i,
  output logic [CB+11:0]  addr_o
);
  localparam int AW = CB + 12;
  logic [CB-1:0] b0_w;
  logic [CB-1:0] b1_w;
  logic [CB-1:0] win8;
  logic [CB-1:0] sel;

  assign b0_w = CB'(bank0_i);
  assign b1_w = CB'(bank1_i);

  generate
    if (CB > 1) begin : g_wide
      assign win8 = {b0_w[CB-1:1], pat_i[12]};
    end else begin : g_one
      assign win8 = pat_i[12];
    end
  endgenerate

  always_comb begin
    if (chr_4k_i) sel = pat_i[12] ? b1_w : b0_w;
    else          sel = win8;
    if (is_ram_i) addr_o = AW'(pat_i);
    else          addr_o = {sel, pat_i[11:0]};
  end
endmodule

// File: rtl/bx_mirror_map.sv
module bx_mirror_map
  import bx_pkg::*;
(
  input  mirror_e      mir_i,
  input  logic [11:0]  nt_i,
  output logic [10:0]  addr_o
);
  always_comb begin
    unique case (mir_i)
      MIR_ONE_LO: addr_o = {1'b0, nt_i[9:0]};
      MIR_ONE_HI: addr_o = {1'b1, nt_i[9:0]};
      MIR_VERT:   addr_o = nt_i[10:0];
      default:    addr_o = {nt_i[11], nt_i[9:0]};
    endcase
  end
endmodule

// File: rtl/bank_xlat.sv
module bank_xlat
  import bx_pkg::*;
#(
  parameter int PRG_LOG2 = 3,
  parameter int CHR_LOG2 = 4,
  localparam int PRG_AW = 14 + PRG_LOG2,
  localparam int CHR_AW = 12 + CHR_LOG2
) (
  input  logic [4:0]        ctrl_i,
  input  logic [3:0]        prg_bank_i,
  input  logic [4:0]        chr_bank0_i,
  input  logic [4:0]        chr_bank1_i,
  input  logic              chr_ram_i,
  input  logic [14:0]       cpu_addr_i,
  input  logic [12:0]       pat_addr_i,
  input  logic [11:0]       nt_addr_i,
  output logic [PRG_AW-1:0] prg_addr_o,
  output logic [CHR_AW-1:0] chr_addr_o,
  output logic [10:0]       ciram_addr_o,
  output logic [12:0]       wram_addr_o
);
  ctrl_t ctl;
  assign ctl = ctrl_t'(ctrl_i);

  bx_prg_map #(.PB(PRG_LOG2)) u_prg (
    .prg_16k_i (ctl.prg_16k),
    .fix_last_i(ctl.fix_last),
    .bank_i    (prg_bank_i),
    .off_i     (cpu_addr_i),
    .addr_o    (prg_addr_o)
  );

  bx_chr_map #(.CB(CHR_LOG2)) u_chr (
    .chr_4k_i(ctl.chr_4k),
    .is_ram_i(chr_ram_i),
    .bank0_i (chr_bank0_i),
    .bank1_i (chr_bank1_i),
    .pat_i   (pat_addr_i),
    .addr_o  (chr_addr_o)
  );

  bx_mirror_map u_mir (
    .mir_i (ctl.mir),
    .nt_i  (nt_addr_i),
    .addr_o(ciram_addr_o)
  );

  assign wram_addr_o = cpu_addr_i[12:0];
endmodule

// File: rtl/bank_xlat_chk.sv
module bank_xlat_chk #(
  parameter int PRG_LOG2 = 3,
  parameter int CHR_LOG2 = 4
) (
  input logic [4:0]             ctrl_i,
  input logic                   chr_ram_i,
  input logic [14:0]            cpu_addr_i,
  input logic [12:0]            pat_addr_i,
  input logic [11:0]            nt_addr_i,
  input logic [13+PRG_LOG2:0]   prg_addr_o,
  input logic [11+CHR_LOG2:0]   chr_addr_o,
  input logic [10:0]            ciram_addr_o
);
  always_comb begin
    if (ctrl_i[3] && ctrl_i[2] && cpu_addr_i[14])
      AST_PRG_LAST_FIXED: assert (&prg_addr_o[13+PRG_LOG2:14]); // R2
    if (ctrl_i[3] && !ctrl_i[2] && !cpu_addr_i[14])
      AST_PRG_FIRST_FIXED: assert (prg_addr_o[13+PRG_LOG2:14] == '0); // R3
    if (!ctrl_i[3])
      AST_PRG_32K_HALF: assert (prg_addr_o[14] == cpu_addr_i[14]); // R1
    if (chr_ram_i)
      AST_CHR_RAM_PASS: assert (chr_addr_o[12:0] == pat_addr_i); // R6
    if (!chr_ram_i && !ctrl_i[4])
      AST_CHR_8K_HALF: assert (chr_addr_o[12] == pat_addr_i[12]); // R5
    if (ctrl_i[1:0] == 2'd1)
      AST_NT_ONE_HI: assert (ciram_addr_o[10]); // R7
    if (ctrl_i[1:0] == 2'd3)
      AST_NT_HORIZ: assert (ciram_addr_o[10] == nt_addr_i[11]); // R8
    AST_NT_LOW_BITS: assert (ciram_addr_o[9:0] == nt_addr_i[9:0]); // R8
  end
endmodule

bind bank_xlat bank_xlat_chk #(.PRG_LOG2(PRG_LOG2), .CHR_LOG2(CHR_LOG2)) u_chk (
  .ctrl_i      (ctrl_i),
  .chr_ram_i   (chr_ram_i),
  .cpu_addr_i  (cpu_addr_i),
  .pat_addr_i  (pat_addr_i),
  .nt_addr_i   (nt_addr_i),
  .prg_addr_o  (prg_addr_o),
  .chr_addr_o  (chr_addr_o),
  .ciram_addr_o(ciram_addr_o)
);

// File: tb/tb_bank_xlat.sv
module tb_bank_xlat;
  localparam int PL = 3;
  localparam int CL = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [4:0]     ctrl_i;
  logic [3:0]     prg_bank_i;
  logic [4:0]     chr_bank0_i, chr_bank1_i;
  logic           chr_ram_i;
  logic [14:0]    cpu_addr_i;
  logic [12:0]    pat_addr_i;
  logic [11:0]    nt_addr_i;
  logic [13+PL:0] prg_addr_o;
  logic [11+CL:0] chr_addr_o;
  logic [10:0]    ciram_addr_o;
  logic [12:0]    wram_addr_o;

  bank_xlat #(.PRG_LOG2(PL), .CHR_LOG2(CL)) dut (.*);

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;
  int unsigned seed = 32'h1234_5678;

  task automatic chk(string req, int got, int exp);
    compared++;
    if (got != exp) begin
      mismatched++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  function automatic int unsigned rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed >> 8;
  endfunction

  function automatic int ref_prg(int c, int b, int a);
    int nb = 1 << PL;
    int bk = b % nb;
    if ((c & 8) == 0) return (bk & ~1) * 16384 + (a & 32'h7FFF);
    if ((c & 4) != 0)
      return ((a >= 16384) ? (nb - 1) : bk) * 16384 + (a & 32'h3FFF);
    return ((a >= 16384) ? bk : 0) * 16384 + (a & 32'h3FFF);
  endfunction

  function automatic int ref_chr(int c, int ram, int b0, int b1, int p);
    int nb = 1 << CL;
    if (ram != 0) return p;
    if ((c & 16) != 0) return (((p >= 4096) ? b1 : b0) % nb) * 4096 + (p & 32'hFFF);
    return ((b0 % nb) & ~1) * 4096 + (p & 32'h1FFF);
  endfunction

  function automatic int ref_nt(int c, int a);
    case (c & 3)
      0: return a & 32'h3FF;
      1: return 32'h400 | (a & 32'h3FF);
      2: return a & 32'h7FF;
      default: return ((a >> 1) & 32'h400) | (a & 32'h3FF);
    endcase
  endfunction

  initial begin
    int fixed_cpu[6] = '{0, 32'h3FFF, 32'h4000, 32'h7FFF, 32'h1234, 32'h6ABC};
    int fixed_pat[4] = '{0, 32'h0FFF, 32'h1000, 32'h1FFF};
    for (int c = 0; c < 32; c++) begin
      for (int k = 0; k < 96; k++) begin
        int ca, pa, na, pb, b0, b1, ram;
        string tp, tc, tn;
        ca = (k < 6) ? fixed_cpu[k] : int'(rnd() & 32'h7FFF);
        pa = (k < 4) ? fixed_pat[k] : int'(rnd() & 32'h1FFF);
        na = (k < 4) ? (k << 10) | 32'h155 : int'(rnd() & 32'hFFF);
        pb = k % 16;
        b0 = int'(rnd() & 31);
        b1 = int'(rnd() & 31);
        ram = (k % 5 == 4) ? 1 : 0;
        @(posedge clk);
        ctrl_i      = c[4:0];
        prg_bank_i  = pb[3:0];
        chr_bank0_i = b0[4:0];
        chr_bank1_i = b1[4:0];
        chr_ram_i   = ram[0];
        cpu_addr_i  = ca[14:0];
        pat_addr_i  = pa[12:0];
        nt_addr_i   = na[11:0];
        @(negedge clk);
        if (pb >= (1 << PL))        tp = "R10 prg wrap";
        else if ((c & 8) == 0)      tp = "R1 prg 32K";
        else if ((c & 4) != 0)      tp = "R2 prg fix last";
        else                        tp = "R3 prg fix first";
        chk(tp, int'(prg_addr_o), ref_prg(c, pb, ca));
        if (ram != 0)               tc = "R6 chr ram";
        else if (b0 >= (1 << CL) || b1 >= (1 << CL)) tc = "R10 chr wrap";
        else if ((c & 16) != 0)     tc = "R4 chr 4K";
        else                        tc = "R5 chr 8K";
        chk(tc, int'(chr_addr_o), ref_chr(c, ram, b0, b1, pa));
        tn = ((c & 3) < 2) ? "R7 one-screen" : "R8 vert/horiz";
        chk(tn, int'(ciram_addr_o), ref_nt(c, na));
        chk("R9 save ram", int'(wram_addr_o), ca & 32'h1FFF);
      end
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog R1 got=hung exp=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule